// File: doc/BRIEF.md
# Per-Channel Buffer Threshold Requester

This block shares one transmit buffer memory among a number of logical channels. Software gives each channel a region of the memory and a low-watermark level. The region is given as a first and a last allocation unit, and one unit is 8 bytes. The block keeps, for each channel, a write pointer at unit granularity for the fetch engine and a read pointer at byte granularity for the consumer. It also keeps a byte count of what is buffered. Both pointers wrap from the last unit of the region back to the first.

When an enabled channel holds fewer bytes than its watermark, the block raises a fetch request toward a memory arbiter. The request carries the channel index and is held until the arbiter acknowledges it. After the acknowledge the channel stays quiet until the fetch engine marks the last unit of that fetch. When several channels qualify, they are granted in rotating order by index. The same watermark also produces a per-channel flag telling the consumer that enough data is buffered to start a new message.

Top module: `bt_threshold_requester`

## Requirements
- R1: After reset no channel is enabled, `req_valid` is 0 and every bit of `start_ok` is 0.
- R2: A configuration write (`cfg_we`) to channel `cfg_ch` sets its region (`cfg_start`..`cfg_end`, in 8-byte units) and its watermark (`cfg_thresh`, in bytes), and sets its enable to `cfg_en`. It also empties the channel: the byte count becomes 0, the write pointer is set to `cfg_start`, the read pointer is set to byte `cfg_start*8`, and any outstanding fetch is cleared.
- R3: A fill (`fill_valid`) adds 8 bytes to the channel's byte count and moves its write pointer one unit, wrapping from `cfg_end` to `cfg_start`. `fill_addr` shows the write pointer of `fill_ch`. A fill is ignored when the channel is disabled or when 8 more bytes would exceed the region size of (end-start+1)*8 bytes.
- R4: A drain (`drain_valid`) removes one byte and moves the read pointer one byte, wrapping from byte `cfg_end*8+7` to `cfg_start*8`. `drain_addr` shows the read pointer of `drain_ch`. A drain on an empty channel is ignored.
- R5: `start_ok[i]` is 1 exactly when channel i is enabled and its byte count is at least its watermark. The flag follows each fill, drain or configuration in the cycle after it.
- R6: A request is raised for an enabled channel whose byte count is below its watermark and which has no fetch outstanding. `req_valid` and `req_ch` stay unchanged until `req_ack`. The request drops in the cycle after the acknowledge.
- R7: After an acknowledge, no new request is raised for that channel until a fill with `fill_last` set arrives for it.
- R8: When more than one channel qualifies, the grant goes to the first one found by searching upward from the channel granted last, wrapping from the highest index to 0.
- R9: A configuration write to the channel whose request is pending withdraws that request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel being configured |
| cfg_en | input | 1 | Enable for the configured channel |
| cfg_start | input | AW | First unit of the region |
| cfg_end | input | AW | Last unit of the region |
| cfg_thresh | input | AW+4 | Low watermark in bytes |
| fill_valid | input | 1 | Fetch engine writes one 8-byte unit |
| fill_ch | input | CH_W | Channel receiving the unit |
| fill_last | input | 1 | Marks the final unit of a fetch |
| fill_addr | output | AW | Current write unit of fill_ch |
| drain_valid | input | 1 | Consumer takes one byte |
| drain_ch | input | CH_W | Channel being drained |
| drain_addr | output | AW+3 | Current read byte of drain_ch |
| req_valid | output | 1 | Fetch request pending |
| req_ch | output | CH_W | Channel of the pending request |
| req_ack | input | 1 | Arbiter accepts the pending request |
| start_ok | output | 2**CH_W | Per-channel message-start permission |

## Verification
The assertions assume that every enabled channel has a region whose last unit is not below its first. They also assume that the arbiter raises `req_ack` only while `req_valid` is high. The stimulus configures only well-formed regions and raises the acknowledge for a single cycle after it has seen a request. It drives fills and drains on one channel at a time, so that the byte count and pointers can be predicted exactly.

// File: rtl/bt_pkg.sv
package bt_pkg;
    typedef enum logic [1:0] {
        EV_NONE  = 2'b00,
        EV_FILL  = 2'b01,
        EV_DRAIN = 2'b10,
        EV_BOTH  = 2'b11
    } bt_event_e;
endpackage

// File: rtl/bt_chan.sv
module bt_chan
    import bt_pkg::*;
#(
    parameter int AW = 12,
    parameter int OW = AW + 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_hit,
    input  logic          cfg_en,
    input  logic [AW-1:0] cfg_start,
    input  logic [AW-1:0] cfg_end,
    input  logic [OW-1:0] cfg_thr,
    input  logic          fill_hit,
    input  logic          fill_last,
    input  logic          drain_hit,
    input  logic          ack_hit,
    output logic [AW-1:0] wptr,
    output logic [AW+2:0] rptr,
    output logic          below,
    output logic          ready,
    output logic          outst
);
    typedef struct packed {
        logic          en;
        logic [AW-1:0] first;
        logic [AW-1:0] last;
        logic [OW-1:0] thr;
        logic [AW-1:0] wptr;
        logic [AW+2:0] rptr;
        logic [OW-1:0] occ;
        logic          outst;
    } chan_st_t;

    chan_st_t  st_q, st_d;
    logic [AW:0]   span;
    logic [OW-1:0] cap;
    logic          fill_ok, drain_ok;
    bt_event_e     ev;

    always_comb begin
        st_d     = st_q;
        span     = {1'b0, st_q.last} - {1'b0, st_q.first} + {{AW{1'b0}}, 1'b1};
        cap      = OW'(span) << 3;
        fill_ok  = fill_hit && st_q.en && (({1'b0, st_q.occ} + (OW+1)'(8)) <= {1'b0, cap});
        drain_ok = drain_hit && st_q.en && (st_q.occ != '0);
        ev       = bt_event_e'({drain_ok, fill_ok});
        case (ev)
            EV_FILL:  st_d.occ = st_q.occ + OW'(8);
            EV_DRAIN: st_d.occ = st_q.occ - OW'(1);
            EV_BOTH:  st_d.occ = st_q.occ + OW'(7);
            default:  st_d.occ = st_q.occ;
        endcase
        if (fill_ok)
            st_d.wptr = (st_q.wptr == st_q.last) ? st_q.first : st_q.wptr + AW'(1);
        if (drain_ok)
            st_d.rptr = (st_q.rptr == {st_q.last, 3'b111}) ? {st_q.first, 3'b000}
                                                           : st_q.rptr + (AW+3)'(1);
        if (fill_hit && fill_last)
            st_d.outst = 1'b0;
        if (ack_hit)
            st_d.outst = 1'b1;
        if (cfg_hit) begin
            st_d.en    = cfg_en;
            st_d.first = cfg_start;
            st_d.last  = cfg_end;
            st_d.thr   = cfg_thr;
            st_d.wptr  = cfg_start;
            st_d.rptr  = {cfg_start, 3'b000};
            st_d.occ   = '0;
            st_d.outst = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wptr  = st_q.wptr;
    assign rptr  = st_q.rptr;
    assign below = st_q.en && (st_q.occ < st_q.thr);
    assign ready = st_q.en && (st_q.occ >= st_q.thr);
    assign outst = st_q.outst;

    // R3: buffered bytes never exceed the region size
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en |-> ({1'b0, st_q.occ} <= {1'b0, cap}));
    // R4: read pointer stays inside the region
    a_r4_rptr_in_region: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en |-> (st_q.rptr[AW+2:3] >= st_q.first && st_q.rptr[AW+2:3] <= st_q.last));
    // R4: drain on an empty channel leaves the read pointer alone
    a_r4_empty_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_hit && !cfg_hit && st_q.occ == '0) |=> $stable(st_q.rptr));
    // R2: configuration empties the channel
    a_r2_cfg_empties: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |=> (st_q.occ == '0 && !st_q.outst));
endmodule

// File: rtl/bt_rr_pick.sv
module bt_rr_pick #(
    parameter int CH_W = 3,
    localparam int N   = 1 << CH_W
) (
    input  logic [N-1:0]    elig,
    input  logic [CH_W-1:0] last,
    output logic            any,
    output logic [CH_W-1:0] pick
);
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = 1; k <= N; k++) begin
            if (!any && elig[last + CH_W'(k)]) begin
                any  = 1'b1;
                pick = last + CH_W'(k);
            end
        end
    end
endmodule

// File: rtl/bt_threshold_requester.sv
module bt_threshold_requester #(
    parameter int CH_W   = 3,
    parameter int AW     = 12,
    localparam int NUM_CH = 1 << CH_W,
    localparam int OW     = AW + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic              cfg_en,
    input  logic [AW-1:0]     cfg_start,
    input  logic [AW-1:0]     cfg_end,
    input  logic [OW-1:0]     cfg_thresh,
    input  logic              fill_valid,
    input  logic [CH_W-1:0]   fill_ch,
    input  logic              fill_last,
    output logic [AW-1:0]     fill_addr,
    input  logic              drain_valid,
    input  logic [CH_W-1:0]   drain_ch,
    output logic [AW+2:0]     drain_addr,
    output logic              req_valid,
    output logic [CH_W-1:0]   req_ch,
    input  logic              req_ack,
    output logic [NUM_CH-1:0] start_ok
);
    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] ch;
        logic [CH_W-1:0] last;
    } req_st_t;

    req_st_t q, d;
    logic [AW-1:0]     wptr_a [NUM_CH];
    logic [AW+2:0]     rptr_a [NUM_CH];
    logic [NUM_CH-1:0] below, outst, elig;
    logic              any, ack_fire;
    logic [CH_W-1:0]   pick;

    assign ack_fire = q.valid && req_ack;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        bt_chan #(.AW(AW), .OW(OW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_hit   (cfg_we && cfg_ch == CH_W'(i)),
            .cfg_en    (cfg_en),
            .cfg_start (cfg_start),
            .cfg_end   (cfg_end),
            .cfg_thr   (cfg_thresh),
            .fill_hit  (fill_valid && fill_ch == CH_W'(i)),
            .fill_last (fill_last),
            .drain_hit (drain_valid && drain_ch == CH_W'(i)),
            .ack_hit   (ack_fire && q.ch == CH_W'(i)),
            .wptr      (wptr_a[i]),
            .rptr      (rptr_a[i]),
            .below     (below[i]),
            .ready     (start_ok[i]),
            .outst     (outst[i])
        );
        assign elig[i] = below[i] && !outst[i] && !(cfg_we && cfg_ch == CH_W'(i));
    end

    bt_rr_pick #(.CH_W(CH_W)) u_pick (
        .elig (elig),
        .last (q.last),
        .any  (any),
        .pick (pick)
    );

    always_comb begin
        d = q;
        if (ack_fire)
            d.valid = 1'b0;
        if (q.valid && cfg_we && cfg_ch == q.ch)
            d.valid = 1'b0;
        if (!q.valid && any) begin
            d.valid = 1'b1;
            d.ch    = pick;
            d.last  = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{valid: 1'b0, ch: '0, last: '1};
        else        q <= d;
    end

    assign req_valid  = q.valid;
    assign req_ch     = q.ch;
    assign fill_addr  = wptr_a[fill_ch];
    assign drain_addr = rptr_a[drain_ch];

    // R6: an unacknowledged request is held steady
    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && !req_ack && !(cfg_we && cfg_ch == q.ch)) |=> (q.valid && $stable(q.ch)));
    // R7: no request for a channel with a fetch outstanding
    a_r7_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> !outst[q.ch]);
    // R9: configuring the requesting channel withdraws the request
    a_r9_cfg_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && cfg_we && cfg_ch == q.ch && !req_ack) |=> !q.valid);
endmodule

// File: tb/bt_threshold_requester_tb.sv
module bt_threshold_requester_tb;
    localparam int CH_W = 3;
    localparam int AW   = 12;
    localparam int N    = 1 << CH_W;
    localparam int OW   = AW + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_en = 1'b0;
    logic [CH_W-1:0] cfg_ch = '0, fill_ch = '0, drain_ch = '0;
    logic [AW-1:0] cfg_start = '0, cfg_end = '0;
    logic [OW-1:0] cfg_thresh = '0;
    logic fill_valid = 1'b0, fill_last = 1'b0, drain_valid = 1'b0, req_ack = 1'b0;
    logic [AW-1:0] fill_addr;
    logic [AW+2:0] drain_addr;
    logic req_valid;
    logic [CH_W-1:0] req_ch;
    logic [N-1:0] start_ok;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bt_threshold_requester #(.CH_W(CH_W), .AW(AW)) u_dut (.*);

    // vector: op (1 fill, 2 drain), expected start_ok[0], fill_addr, drain_addr
    localparam logic [29:0] VEC [10] = '{
        {2'd1, 1'b0, 12'd5, 15'd32},
        {2'd1, 1'b1, 12'd4, 15'd32},
        {2'd1, 1'b1, 12'd4, 15'd32},
        {2'd2, 1'b1, 12'd4, 15'd33},
        {2'd2, 1'b1, 12'd4, 15'd34},
        {2'd2, 1'b1, 12'd4, 15'd35},
        {2'd2, 1'b1, 12'd4, 15'd36},
        {2'd2, 1'b1, 12'd4, 15'd37},
        {2'd2, 1'b1, 12'd4, 15'd38},
        {2'd2, 1'b0, 12'd4, 15'd39}
    };

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg(int ch, bit en, int s, int e, int thr);
        cfg_we = 1'b1; cfg_ch = CH_W'(ch); cfg_en = en;
        cfg_start = AW'(s); cfg_end = AW'(e); cfg_thresh = OW'(thr);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic ack();
        req_ack = 1'b1;
        step();
        req_ack = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1 req_valid", int'(req_valid), 0);
        chk("R1 start_ok", int'(start_ok), 0);

        cfg(0, 1'b1, 4, 5, 10);
        chk("R2 empty fill_addr", int'(fill_addr), 4);
        chk("R2 empty drain_addr", int'(drain_addr), 32);
        step();
        chk("R6 req raised", int'(req_valid), 1);
        chk("R6 req_ch", int'(req_ch), 0);
        ack();
        chk("R6 req drops after ack", int'(req_valid), 0);

        for (int i = 0; i < 10; i++) begin
            if (VEC[i][29:28] == 2'd1) fill_valid = 1'b1;
            else drain_valid = 1'b1;
            step();
            fill_valid = 1'b0; drain_valid = 1'b0;
            chk("R5 start_ok", int'(start_ok[0]), int'(VEC[i][27]));
            chk("R3 fill_addr", int'(fill_addr), int'(VEC[i][26:15]));
            chk("R4 drain_addr", int'(drain_addr), int'(VEC[i][14:0]));
        end
        chk("R7 no request while outstanding", int'(req_valid), 0);

        for (int i = 0; i < 9; i++) begin
            drain_valid = 1'b1;
            step();
        end
        drain_valid = 1'b0;
        chk("R4 read pointer wraps", int'(drain_addr), 32);
        drain_valid = 1'b1;
        step();
        drain_valid = 1'b0;
        chk("R4 empty drain ignored", int'(drain_addr), 32);
        chk("R5 empty start_ok", int'(start_ok[0]), 0);
        chk("R7 still quiet", int'(req_valid), 0);

        fill_valid = 1'b1; fill_last = 1'b1;
        step();
        fill_valid = 1'b0; fill_last = 1'b0;
        chk("R3 fill after wrap", int'(fill_addr), 5);
        chk("R7 release cycle", int'(req_valid), 0);
        step();
        chk("R7 re-request", int'(req_valid), 1);
        repeat (3) step();
        chk("R6 held valid", int'(req_valid), 1);
        chk("R6 held ch", int'(req_ch), 0);

        cfg(0, 1'b1, 4, 5, 0);
        chk("R9 withdrawn", int'(req_valid), 0);
        chk("R5 zero watermark", int'(start_ok[0]), 1);
        step();
        chk("R9 stays quiet", int'(req_valid), 0);

        fill_ch = 3'd5; fill_valid = 1'b1;
        step();
        fill_valid = 1'b0;
        chk("R3 disabled fill ignored", int'(fill_addr), 0);
        chk("R3 disabled start_ok", int'(start_ok[5]), 0);
        fill_ch = '0;

        cfg(2, 1'b1, 10, 11, 8);
        cfg(3, 1'b1, 20, 21, 8);
        cfg(1, 1'b1, 30, 31, 8);
        chk("R8 first grant", int'(req_ch), 2);
        ack();
        step();
        chk("R8 next above", int'(req_valid), 1);
        chk("R8 ch3 before ch1", int'(req_ch), 3);
        ack();
        step();
        chk("R8 wrap to ch1", int'(req_ch), 1);
        ack();
        step();
        chk("R7 all outstanding", int'(req_valid), 0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule